// File: doc/BRIEF.md
# Multi-Channel ADC Conversion Sequencer

This block is the digital controller of a multi-channel successive-approximation analog-to-digital converter. Software programs a single control/status register with a run bit, a single/repeat mode bit, a channel field, an interrupt enable and a completion flag. It then reads one result register per channel. Behind the register port, the sequencer drives an abstract converter core through a sample-and-hold enable, a conversion request, a channel number and a completion handshake that carries the result.

A start first waits for a free-running four-phase timing counter to wrap, so the delay from the write to the start of sampling varies between one and four cycles. Each channel then gets an eight-cycle sample window and a conversion phase that lasts until the core reports completion. The result is stored in one clock. In single mode one channel is converted and the run bit clears itself. In repeat mode channels 0 up to the selected channel are converted in ascending order, pass after pass, until software clears the run bit.

Register map: address 0 is the control/status register and address 4+n is the result of channel n. Control bits: bit0 run, bit1 repeat mode, bits 3:2 channel field, bit4 interrupt enable, bit5 completion flag.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset the control register reads 0, all four result registers read 0, and sampleHold, convReq and irq are low.
- R2: After a write of 1 to bit0 while idle, sampleHold rises between 1 and 4 clock edges later, depending on the phase of a free-running 4-phase counter. Writes made in four consecutive phase slots give all four latencies.
- R3: sampleHold stays high for exactly 8 cycles. convReq rises in the cycle that follows, and only ever right after a sample window.
- R4: A result register changes only on the clock edge that samples convDone high during a conversion, and it takes convResult in that single edge.
- R5: In single mode (bit1 = 0) only the channel in bits 3:2 is converted, once. Bit0 then reads 0, bit5 reads 1, and the other result registers keep their values.
- R6: In repeat mode (bit1 = 1) channels 0 up to the value of bits 3:2 are converted in ascending order. Bit5 is set after the last channel of each pass. Sampling of channel 0 starts in the cycle after the last completion, with no phase wait. Results can be read mid-run without stopping it.
- R7: A write of 0 to bit0 while running drops sampleHold and convReq at the next edge. No result register is updated afterwards and bit5 is not set.
- R8: A write of 0 to bit5 clears the flag only if the control register was read with bit5 = 1 since the flag was last set. Otherwise the flag stays at 1.
- R9: When a completion sets the flag in the same cycle as a clearing write, the flag stays at 1.
- R10: irq is high exactly when bit5 and bit4 are both 1.
- R11: While running, writes to bits 1 and 3:2 have no effect. Bit4 stays writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | 3 | Register address (0 control, 4+n result n) |
| wrEn | input | 1 | Register write strobe |
| wrData | input | 8 | Write data for the control register |
| rdEn | input | 1 | Register read strobe (arms flag clearing) |
| rdData | output | RES_W | Read data, combinational from regAddr |
| sampleHold | output | 1 | Sample-and-hold enable for the core |
| convReq | output | 1 | Conversion request to the core |
| chanOut | output | 2 | Channel being sampled or converted |
| convDone | input | 1 | Core completion pulse |
| convResult | input | RES_W | Core result, valid with convDone |
| irq | output | 1 | Completion interrupt |

## Verification
Register writes and reads take effect at the clock edge that samples their strobe. sampleHold therefore rises 1 to 4 edges after a start write, and convReq follows 8 edges after that. A result register changes at the edge that samples convDone, so the bench reads it at the falling edge where convDone is high and expects the old value, then reads it one falling edge later and expects the new one. Stop and flag effects are checked at the first falling edge after the write. All sampling happens on falling edges, and the bench's core model raises convDone ten cycles after convReq.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int SEL_W  = 2;
  localparam int NUM_CH = 1 << SEL_W;
  localparam int ADDR_W = SEL_W + 1;
  localparam int CTRL_W = 8;

  // control register bit positions
  localparam int B_RUN  = 0;
  localparam int B_SCAN = 1;
  localparam int B_GRP  = 2;
  localparam int B_IEN  = B_GRP + SEL_W;
  localparam int B_END  = B_IEN + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_SYNC, ST_SAMPLE, ST_CONV} seqState_t;

  typedef struct packed {
    logic             store;
    logic [SEL_W-1:0] chan;
  } dpStrobe_t;
endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int PHASE_N    = 4,
  parameter int SAMPLE_CYC = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              convDone,
  output dpStrobe_t         strobe,
  output logic [CTRL_W-1:0] ctrlRdVal,
  output logic              sampleHold,
  output logic              convReq,
  output logic [SEL_W-1:0]  chanOut,
  output logic              irq
);
  localparam int PH_W = (PHASE_N > 1) ? $clog2(PHASE_N) : 1;
  localparam int SM_W = (SAMPLE_CYC > 1) ? $clog2(SAMPLE_CYC) : 1;

  seqState_t        state;
  logic [PH_W-1:0]  phaseCnt;
  logic [SM_W-1:0]  smpCnt;
  logic [SEL_W-1:0] grpSel, curCh;
  logic             scanMode, intEn, endFlag, clrArmed;
  logic             ctrlWr, ctrlRd, running, launch, stopReq;
  logic             convEnd, setEvt, clrReq, phaseWrap, smpLast;

  assign ctrlWr    = wrEn && (regAddr == '0);
  assign ctrlRd    = rdEn && (regAddr == '0);
  assign running   = (state != ST_IDLE);
  assign launch    = ctrlWr && wrData[B_RUN] && !running;
  assign stopReq   = ctrlWr && !wrData[B_RUN] && running;
  assign convEnd   = (state == ST_CONV) && convDone && !stopReq;
  assign setEvt    = convEnd && (curCh == grpSel);
  assign clrReq    = ctrlWr && !wrData[B_END] && clrArmed;
  assign phaseWrap = (phaseCnt == PH_W'(PHASE_N - 1));
  assign smpLast   = (smpCnt == SM_W'(SAMPLE_CYC - 1));

  // free-running timing phase
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) phaseCnt <= '0;
    else       phaseCnt <= phaseWrap ? '0 : phaseCnt + 1'b1;
  end

  // completion flag with read-before-clear arming; set wins
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      endFlag  <= 1'b0;
      clrArmed <= 1'b0;
    end else begin
      if (setEvt)      endFlag <= 1'b1;
      else if (clrReq) endFlag <= 1'b0;
      if (setEvt || clrReq)       clrArmed <= 1'b0;
      else if (ctrlRd && endFlag) clrArmed <= 1'b1;
    end
  end

  // configuration fields, locked while running
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intEn    <= 1'b0;
      scanMode <= 1'b0;
      grpSel   <= '0;
    end else if (ctrlWr) begin
      intEn <= wrData[B_IEN];
      if (!running) begin
        scanMode <= wrData[B_SCAN];
        grpSel   <= wrData[B_GRP +: SEL_W];
      end
    end
  end

  // sequencer
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      smpCnt <= '0;
      curCh  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (launch) begin
          state <= ST_SYNC;
          curCh <= wrData[B_SCAN] ? '0 : wrData[B_GRP +: SEL_W];
        end
        ST_SYNC: if (phaseWrap) begin
          state  <= ST_SAMPLE;
          smpCnt <= '0;
        end
        ST_SAMPLE: begin
          if (smpLast) state <= ST_CONV;
          else         smpCnt <= smpCnt + 1'b1;
        end
        ST_CONV: if (convEnd) begin
          if (!scanMode) begin
            state <= ST_IDLE;
          end else begin
            state  <= ST_SAMPLE;
            smpCnt <= '0;
            curCh  <= (curCh == grpSel) ? '0 : curCh + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
      if (stopReq) state <= ST_IDLE;
    end
  end

  assign strobe.store = convEnd;
  assign strobe.chan  = curCh;
  assign sampleHold   = (state == ST_SAMPLE);
  assign convReq      = (state == ST_CONV);
  assign chanOut      = curCh;
  assign irq          = endFlag && intEn;

  always_comb begin
    ctrlRdVal                     = '0;
    ctrlRdVal[B_RUN]              = running;
    ctrlRdVal[B_SCAN]             = scanMode;
    ctrlRdVal[B_GRP +: SEL_W]     = grpSel;
    ctrlRdVal[B_IEN]              = intEn;
    ctrlRdVal[B_END]              = endFlag;
  end

  // R3: a conversion request only ever follows a sample window
  a_r3_conv_after_sample: assert property (@(posedge clk) disable iff (!rstN)
    $rose(convReq) |-> $past(sampleHold));
  // R6: repeat mode moves straight into the next sample window
  a_r6_wrap_no_sync: assert property (@(posedge clk) disable iff (!rstN)
    (convEnd && scanMode) |=> sampleHold);
  // R7: a stop write idles the core interface at the next edge
  a_r7_stop_idles: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> (!sampleHold && !convReq));
  // R8: an unarmed flag cannot be cleared
  a_r8_unarmed_keeps: assert property (@(posedge clk) disable iff (!rstN)
    (endFlag && !clrArmed) |=> endFlag);
  // R9: a set event beats a clearing write
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rstN)
    setEvt |=> endFlag);
endmodule

// File: rtl/adc_scan_datapath.sv
module adc_scan_datapath
  import adc_scan_pkg::*;
#(
  parameter int RES_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobe_t         strobe,
  input  logic [RES_W-1:0]  convResult,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [CTRL_W-1:0] ctrlRdVal,
  output logic [RES_W-1:0]  rdData
);
  logic [RES_W-1:0] resReg [NUM_CH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_CH; i++) resReg[i] <= '0;
    end else if (strobe.store) begin
      resReg[strobe.chan] <= convResult;
    end
  end

  generate
    for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
      // R4: a result register moves only on its own store strobe
      a_r4_hold_unless_stored: assert property (@(posedge clk) disable iff (!rstN)
        !(strobe.store && strobe.chan == SEL_W'(g)) |=> $stable(resReg[g]));
    end
  endgenerate

  always_comb begin
    rdData = '0;
    if (regAddr[ADDR_W-1])   rdData = resReg[regAddr[SEL_W-1:0]];
    else if (regAddr == '0)  rdData = RES_W'(ctrlRdVal);
  end
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int RES_W      = 10,
  parameter int PHASE_N    = 4,
  parameter int SAMPLE_CYC = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wrEn,
  input  logic [CTRL_W-1:0] wrData,
  input  logic              rdEn,
  output logic [RES_W-1:0]  rdData,
  output logic              sampleHold,
  output logic              convReq,
  output logic [SEL_W-1:0]  chanOut,
  input  logic              convDone,
  input  logic [RES_W-1:0]  convResult,
  output logic              irq
);
  dpStrobe_t         strobe;
  logic [CTRL_W-1:0] ctrlRdVal;

  adc_scan_ctrl #(.PHASE_N(PHASE_N), .SAMPLE_CYC(SAMPLE_CYC)) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .convDone(convDone), .strobe(strobe),
    .ctrlRdVal(ctrlRdVal), .sampleHold(sampleHold), .convReq(convReq),
    .chanOut(chanOut), .irq(irq)
  );

  adc_scan_datapath #(.RES_W(RES_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .convResult(convResult),
    .regAddr(regAddr), .ctrlRdVal(ctrlRdVal), .rdData(rdData)
  );
endmodule

// File: tb/adc_scan_seq_test.sv
module adc_scan_seq_test;
  import adc_scan_pkg::*;
  localparam int RES_W    = 10;
  localparam int CONV_CYC = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [CTRL_W-1:0] wrData = '0;
  logic [RES_W-1:0] rdData, convResult;
  logic sampleHold, convReq, irq;
  logic [SEL_W-1:0] chanOut;
  logic convDone = 1'b0;
  logic [RES_W-1:0] analogIn [NUM_CH];
  int coreCnt = 0;
  int cyc = 0;
  int nTests = 0, nFail = 0;
  int chLog [64];
  int logN = 0;
  logic prevReq = 1'b0;

  always #5 clk = ~clk;

  adc_scan_seq uut (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdEn(rdEn), .rdData(rdData), .sampleHold(sampleHold), .convReq(convReq),
    .chanOut(chanOut), .convDone(convDone), .convResult(convResult), .irq(irq)
  );

  assign convResult = analogIn[chanOut];

  // converter core model: completion CONV_CYC cycles after the request rises
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!convReq || convDone) begin
      coreCnt  <= 0;
      convDone <= 1'b0;
    end else begin
      coreCnt <= coreCnt + 1;
      if (coreCnt == CONV_CYC - 2) convDone <= 1'b1;
    end
  end

  // log the channel of every conversion start
  always @(negedge clk) begin
    if (convReq && !prevReq && logN < 64) begin
      chLog[logN] = int'(chanOut);
      logN = logN + 1;
    end
    prevReq = convReq;
  end

  task automatic chk(input string req, input int act, input int exp);
    nTests++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic doWrite(input int d);
    regAddr = '0; wrData = CTRL_W'(d); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic doRead(output int v);
    regAddr = '0; rdEn = 1'b1;
    #1 v = int'(rdData);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic peek(input int ch, output int v);
    regAddr = ADDR_W'(NUM_CH + ch);
    #1 v = int'(rdData);
  endtask

  task automatic waitIrq();
    for (int k = 0; k < 400 && !irq; k++) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    int v, lat, n, base, seen;
    for (int i = 0; i < NUM_CH; i++) analogIn[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    doRead(v); chk("R1 control", v, 0);
    for (int i = 0; i < NUM_CH; i++) begin peek(i, v); chk("R1 result", v, 0); end
    chk("R1 outputs", int'({sampleHold, convReq, irq}), 0);

    // R2/R3/R4/R5 single conversions at four phase slots
    seen = 0;
    for (int j = 0; j < NUM_CH; j++) begin
      analogIn[j] = RES_W'(100 + j * 77);
      while (cyc % 4 != j) @(negedge clk);
      doWrite(1 | (j << B_GRP));
      lat = 0;
      while (!sampleHold && lat < 10) begin @(negedge clk); lat++; end
      chk("R2 latency in 1..4", int'(lat >= 1 && lat <= 4), 1);
      if (lat >= 1 && lat <= 4) seen |= 1 << (lat - 1);
      chk("R5 selected channel", int'(chanOut), j);
      n = 0;
      while (sampleHold && n < 20) begin @(negedge clk); n++; end
      chk("R3 sample length", n, 8);
      chk("R3 convReq after sampling", int'(convReq), 1);
      n = 0;
      while (!convDone && n < 20) begin @(negedge clk); n++; end
      peek(j, v); chk("R4 before store edge", v, 0);
      @(negedge clk);
      peek(j, v); chk("R4 stored value", v, 100 + j * 77);
      chk("R5 single stops", int'({sampleHold, convReq}), 0);
      repeat (3) @(negedge clk);
    end
    chk("R2 all four latencies seen", seen, 15);
    for (int i = 0; i < NUM_CH; i++) begin peek(i, v); chk("R5 others kept", v, 100 + i * 77); end

    // R10 / R8 flag and interrupt
    chk("R10 irq masked", int'(irq), 0);
    doWrite(16 | (3 << B_GRP));
    chk("R8 unarmed clear ignored, R10 irq", int'(irq), 1);
    doRead(v); chk("R5 status after single", v, 32 | 16 | (3 << B_GRP));
    doWrite(16 | (3 << B_GRP));
    chk("R8 armed clear", int'(irq), 0);

    // R6 / R11 repeat mode
    for (int i = 0; i < NUM_CH; i++) analogIn[i] = RES_W'(200 + i * 50);
    base = logN;
    doWrite(1 | 2 | (3 << B_GRP) | 16);
    doWrite(1 | 32 | 16);
    doRead(v); chk("R11 fields locked", v & 31, 31);
    waitIrq();
    chk("R6 flag after pass", int'(irq), 1);
    for (int i = 0; i < NUM_CH; i++) chk("R6 order pass 1", chLog[base + i], i);
    for (int i = 0; i < NUM_CH; i++) begin peek(i, v); chk("R6 result mid-run", v, 200 + i * 50); end
    chk("R6 still running", int'(sampleHold || convReq), 1);
    for (int i = 0; i < NUM_CH; i++) analogIn[i] = RES_W'(400 + i * 30);
    doRead(v);
    doWrite(1 | 2 | (3 << B_GRP) | 16);
    chk("R8 clear while running", int'(irq), 0);
    n = 0;
    while (!(convDone && chanOut == 2'd3) && n < 200) begin @(negedge clk); n++; end
    @(negedge clk);
    chk("R6 wrap without sync", int'({sampleHold, chanOut}), 4);
    chk("R6 flag again", int'(irq), 1);
    for (int i = 0; i < NUM_CH; i++) chk("R6 order pass 2", chLog[base + NUM_CH + i], i);
    for (int i = 0; i < NUM_CH; i++) begin peek(i, v); chk("R6 pass 2 result", v, 400 + i * 30); end

    // R7 stop mid-scan
    for (int i = 0; i < NUM_CH; i++) analogIn[i] = RES_W'(600 + i * 20);
    doRead(v);
    doWrite(1 | 2 | (3 << B_GRP) | 16);
    n = 0;
    while (!(convReq && chanOut == 2'd2) && n < 200) begin @(negedge clk); n++; end
    repeat (3) @(negedge clk);
    doWrite(16);
    chk("R7 interface idle", int'({sampleHold, convReq}), 0);
    n = 0;
    for (int k = 0; k < 40; k++) begin @(negedge clk); if (sampleHold || convReq) n++; end
    chk("R7 stays idle", n, 0);
    peek(0, v); chk("R7 ch0 updated", v, 600);
    peek(1, v); chk("R7 ch1 updated", v, 620);
    peek(2, v); chk("R7 ch2 not updated", v, 460);
    peek(3, v); chk("R7 ch3 not updated", v, 490);
    chk("R7 no flag", int'(irq), 0);
    doRead(v); chk("R7 run bit clear", v & 33, 0);

    // R9 set beats clear
    analogIn[0] = RES_W'(77);
    doWrite(1 | 2 | 16);
    waitIrq();
    doRead(v);
    n = 0;
    while (!convDone && n < 100) begin @(negedge clk); n++; end
    doWrite(1 | 2 | 16);
    chk("R9 set wins", int'(irq), 1);
    doWrite(1 | 2 | 16);
    chk("R8 new set needs read", int'(irq), 1);
    doWrite(0);

    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule